// File: doc/BRIEF.md
# Four-Entry Shift-Replacement Branch Target Buffer

This block is a small, fully associative store of taken-branch destinations for the fetch stage of a pipelined processor. Each slot pairs a branch address tag with the destination the branch jumped to. When the direction predictor reports that the conditional branch in fetch will be taken, fetch raises a lookup with the branch address. If a slot matches, the block returns a redirect address and that address plus one in the same cycle, so the next fetch can begin there.

Writes come from the resolve stage. Only a branch that has resolved as taken is recorded. A branch that is already stored has its destination rewritten in its own slot. A new branch goes into the lowest free slot. When every slot is occupied, all slots move one place toward slot 0, the contents of slot 0 are lost, and the new branch lands in the highest slot. The oldest insertion is therefore always the one that leaves. Direction prediction and misprediction recovery are handled outside the block.

Top module: `btb_fifo_top`

## Requirements
- R1: After reset every slot is empty, and no lookup hits until a taken branch has been written. This includes a lookup of address 0x0000.
- R2: While `lk_valid` is low, `lk_hit` is low and both redirect outputs are zero, whatever is stored.
- R3: A lookup whose `lk_pc` equals the tag of an occupied slot hits in the same cycle. `lk_next_pc` then gives the stored 16-bit destination, and `lk_next_pc_inc` gives that destination plus one, wrapping modulo 65536 (0xFFFF gives 0x0000).
- R4: A lookup of an address held in no occupied slot misses, and both redirect outputs are zero.
- R5: A resolved branch with `upd_taken` low writes nothing. Its address still misses afterwards, and no stored branch is displaced.
- R6: Free slots are filled lowest index first. Four distinct taken branches are all retained, and none is evicted while a slot is still free.
- R7: When all four slots are occupied and a new taken branch arrives, the branch inserted earliest is dropped and the three others plus the new one stay hit-able. A second such insertion drops the next-oldest.
- R8: A taken branch whose address is already stored updates that slot's destination in place. It uses no free slot and causes no eviction.
- R9: A lookup made in the same cycle as a write sees the contents from before the write. The written branch hits from the next cycle. A branch evicted by that write still hits in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request: branch in fetch predicted taken |
| lk_pc | input | PC_W | Address of the branch in fetch |
| lk_hit | output | 1 | A stored branch matched the lookup |
| lk_next_pc | output | TGT_W | Redirect address on a hit, else zero |
| lk_next_pc_inc | output | TGT_W | Redirect address plus one on a hit, else zero |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_taken | input | 1 | The resolved branch was taken |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | TGT_W | Destination of the resolved branch |

## Verification
A fetch-side lookup and a resolve-side write can land in the same clock cycle, and the lookup must answer from the old contents. The bench provokes this twice. The first time, a write and a lookup of the same new address share a cycle on an empty buffer, and the lookup must miss then and hit one cycle later. The second time, the buffer is full and a write forces an eviction while the lookup targets the branch about to leave. That branch must still hit with its old destination in that cycle, then miss afterwards.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Kind of change applied to the slot array on a clock edge.
  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,
    WR_RETARGET = 2'd1,
    WR_FILL     = 2'd2,
    WR_SHIFT    = 2'd3
  } wr_op_e;

  localparam int unsigned BTB_ENTRIES_DEF = 4;
  localparam int unsigned BTB_PC_W_DEF    = 16;
  localparam int unsigned BTB_TGT_W_DEF   = 16;

endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned PC_W  = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [PC_W-1:0]             key,
  input  logic [N_ENT-1:0]            vld,
  input  logic [N_ENT-1:0][PC_W-1:0]  tags,
  output logic                        any_match,
  output logic [IDX_W-1:0]            match_idx
);

  logic [N_ENT-1:0] match_vec;

  // One comparator per slot.
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_vec[g] = vld[g] && (tags[g] == key);
  end

  assign any_match = |match_vec;

  // Ascending scan: the highest matching index wins.
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match_vec[i]) begin
        match_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/btb_alloc.sv
module btb_alloc
  import btb_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             req,
  input  logic             taken,
  input  logic             present,
  input  logic [IDX_W-1:0] present_idx,
  input  logic [N_ENT-1:0] vld,
  output wr_op_e           op,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  // Descending scan: the lowest free index wins.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    op  = WR_NONE;
    idx = '0;
    if (req && taken) begin
      if (present) begin
        op  = WR_RETARGET;
        idx = present_idx;
      end else if (free_found) begin
        op  = WR_FILL;
        idx = free_idx;
      end else begin
        op  = WR_SHIFT;
        idx = LAST_IDX;
      end
    end
  end

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned PC_W  = 16,
  parameter int unsigned TGT_W = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wr_op_e                      op,
  input  logic [IDX_W-1:0]            idx,
  input  logic [PC_W-1:0]             wr_tag,
  input  logic [TGT_W-1:0]            wr_tgt,
  output logic [N_ENT-1:0]            vld_q,
  output logic [N_ENT-1:0][PC_W-1:0]  tag_q,
  output logic [N_ENT-1:0][TGT_W-1:0] tgt_q
);

  logic [N_ENT-1:0]            vld_d;
  logic [N_ENT-1:0][PC_W-1:0]  tag_d;
  logic [N_ENT-1:0][TGT_W-1:0] tgt_d;
  logic                        ent_en;

  assign ent_en = (op != WR_NONE);

  // Next-state of the slot array.
  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    tgt_d = tgt_q;
    unique case (op)
      WR_RETARGET: begin
        tgt_d[idx] = wr_tgt;
      end
      WR_FILL: begin
        vld_d[idx] = 1'b1;
        tag_d[idx] = wr_tag;
        tgt_d[idx] = wr_tgt;
      end
      WR_SHIFT: begin
        for (int i = 0; i < N_ENT - 1; i++) begin
          vld_d[i] = vld_q[i+1];
          tag_d[i] = tag_q[i+1];
          tgt_d[i] = tgt_q[i+1];
        end
        vld_d[N_ENT-1] = 1'b1;
        tag_d[N_ENT-1] = wr_tag;
        tgt_d[N_ENT-1] = wr_tgt;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      tgt_q <= '0;
    end else if (ent_en) begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      tgt_q <= tgt_d;
    end
  end

endmodule

// File: rtl/btb_fifo_top.sv
module btb_fifo_top
  import btb_pkg::*;
#(
  parameter int unsigned N_ENT = BTB_ENTRIES_DEF,
  parameter int unsigned PC_W  = BTB_PC_W_DEF,
  parameter int unsigned TGT_W = BTB_TGT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_next_pc,
  output logic [TGT_W-1:0] lk_next_pc_inc,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [TGT_W-1:0] upd_target
);

  localparam int unsigned IDX_W = $clog2(N_ENT);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [N_ENT-1:0]            vld_q;
  logic [N_ENT-1:0][PC_W-1:0]  tag_q;
  logic [N_ENT-1:0][TGT_W-1:0] tgt_q;

  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic             up_any;
  logic [IDX_W-1:0] up_idx;
  wr_op_e           wr_op;
  logic [IDX_W-1:0] wr_idx;

  // Fetch-side search.
  btb_match #(.N_ENT(N_ENT), .PC_W(PC_W)) u_lk_match (
    .key       (lk_pc),
    .vld       (vld_q),
    .tags      (tag_q),
    .any_match (lk_any),
    .match_idx (lk_idx)
  );

  // Resolve-side search for an existing copy of the branch.
  btb_match #(.N_ENT(N_ENT), .PC_W(PC_W)) u_up_match (
    .key       (upd_pc),
    .vld       (vld_q),
    .tags      (tag_q),
    .any_match (up_any),
    .match_idx (up_idx)
  );

  btb_alloc #(.N_ENT(N_ENT)) u_alloc (
    .req         (upd_valid),
    .taken       (upd_taken),
    .present     (up_any),
    .present_idx (up_idx),
    .vld         (vld_q),
    .op          (wr_op),
    .idx         (wr_idx)
  );

  btb_store #(.N_ENT(N_ENT), .PC_W(PC_W), .TGT_W(TGT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .op     (wr_op),
    .idx    (wr_idx),
    .wr_tag (upd_pc),
    .wr_tgt (upd_target),
    .vld_q  (vld_q),
    .tag_q  (tag_q),
    .tgt_q  (tgt_q)
  );

  logic [TGT_W-1:0] sel_tgt;

  assign sel_tgt        = tgt_q[lk_idx];
  assign lk_hit         = lk_valid && lk_any;
  assign lk_next_pc     = lk_hit ? sel_tgt : '0;
  assign lk_next_pc_inc = lk_hit ? (sel_tgt + TGT_W'(1)) : '0;

endmodule

// File: rtl/btb_fifo_chk.sv
module btb_fifo_chk #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned PC_W  = 16,
  parameter int unsigned TGT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_hit,
  input logic [TGT_W-1:0] lk_next_pc,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic [PC_W-1:0]  upd_pc,
  input logic [TGT_W-1:0] upd_target,
  input logic [N_ENT-1:0] vld
);

  localparam logic [N_ENT-1:0] ONE_V = {{(N_ENT-1){1'b0}}, 1'b1};

  // Set once any taken branch has been presented since reset.
  logic seen_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr_q <= 1'b0;
    end else if (upd_valid && upd_taken) begin
      seen_wr_q <= 1'b1;
    end
  end

  // R1: nothing hits before the first write.
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr_q |-> !lk_hit);

  // R2: idle lookup port stays quiet.
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && (lk_next_pc == '0)));

  // R3: a branch written last cycle hits with its destination now.
  p_fresh_entry_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(upd_valid && upd_taken) && (lk_pc == $past(upd_pc)))
      |-> (lk_hit && (lk_next_pc == $past(upd_target))));

  // R5: a not-taken resolution leaves occupancy unchanged.
  p_ignore_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> $stable(vld));

  // R6: occupied slots always form a run starting at slot 0.
  p_fill_from_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld + ONE_V) & vld) == '0);

  // R7: occupancy never shrinks outside reset.
  p_never_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) >= $countones($past(vld)));

endmodule

bind btb_fifo_top btb_fifo_chk #(.N_ENT(N_ENT), .PC_W(PC_W), .TGT_W(TGT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .lk_valid   (lk_valid),
  .lk_pc      (lk_pc),
  .lk_hit     (lk_hit),
  .lk_next_pc (lk_next_pc),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .upd_pc     (upd_pc),
  .upd_target (upd_target),
  .vld        (vld_q)
);

// File: tb/btb_fifo_top_tb_top.sv
module btb_fifo_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [15:0] lk_pc;
  logic        lk_hit;
  logic [15:0] lk_next_pc;
  logic [15:0] lk_next_pc_inc;
  logic        upd_valid;
  logic        upd_taken;
  logic [15:0] upd_pc;
  logic [15:0] upd_target;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  btb_fifo_top dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_pc          (lk_pc),
    .lk_hit         (lk_hit),
    .lk_next_pc     (lk_next_pc),
    .lk_next_pc_inc (lk_next_pc_inc),
    .upd_valid      (upd_valid),
    .upd_taken      (upd_taken),
    .upd_pc         (upd_pc),
    .upd_target     (upd_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYCLES && !done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG_CYCLES);
      summary();
    end
  end

  task automatic apply_reset();
    lk_valid = 0; lk_pc = '0;
    upd_valid = 0; upd_taken = 0; upd_pc = '0; upd_target = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  // Compare the lookup outputs that are visible right now.
  task automatic cmp(string req, logic [15:0] pc, bit exp_hit, logic [15:0] exp_npc);
    logic [15:0] e_npc;
    logic [15:0] e_inc;
    e_npc = exp_hit ? exp_npc : 16'h0000;
    e_inc = exp_hit ? exp_npc + 16'h0001 : 16'h0000;
    n_checks++;
    if (lk_hit !== exp_hit || lk_next_pc !== e_npc || lk_next_pc_inc !== e_inc) begin
      n_fails++;
      $display("FAIL %s pc=%h: actual hit=%0b npc=%h inc=%h expected hit=%0b npc=%h inc=%h",
               req, pc, lk_hit, lk_next_pc, lk_next_pc_inc, exp_hit, e_npc, e_inc);
    end
  endtask

  task automatic look(string req, logic [15:0] pc, bit exp_hit, logic [15:0] exp_npc);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc;
    #1 cmp(req, pc, exp_hit, exp_npc);
    lk_valid = 0;
  endtask

  task automatic put(logic [15:0] pc, logic [15:0] tgt, bit taken);
    @(negedge clk);
    upd_valid = 1; upd_taken = taken; upd_pc = pc; upd_target = tgt;
    @(posedge clk);
    #1 upd_valid = 0; upd_taken = 0;
  endtask

  // R1, R4: empty after reset, including address zero.
  task automatic t_reset();
    apply_reset();
    look("R1", 16'h0000, 0, 16'h0);
    look("R1", 16'h0010, 0, 16'h0);
    look("R4", 16'hFFFF, 0, 16'h0);
  endtask

  // R6, R3: fill four slots; all retained.
  task automatic t_fill();
    put(16'h0100, 16'h2000, 1);
    put(16'h0104, 16'h2100, 1);
    put(16'h0108, 16'h2200, 1);
    put(16'h010C, 16'h2300, 1);
    look("R6", 16'h0100, 1, 16'h2000);
    look("R3", 16'h0104, 1, 16'h2100);
    look("R6", 16'h0108, 1, 16'h2200);
    look("R6", 16'h010C, 1, 16'h2300);
    look("R4", 16'h0102, 0, 16'h0);
  endtask

  // R2: idle lookup port on a stored address.
  task automatic t_idle();
    @(negedge clk);
    lk_valid = 0; lk_pc = 16'h0100;
    #1 cmp("R2", 16'h0100, 0, 16'h0);
  endtask

  // R5: not-taken resolution on a full buffer writes and evicts nothing.
  task automatic t_not_taken();
    put(16'h0200, 16'h3000, 0);
    look("R5", 16'h0200, 0, 16'h0);
    look("R5", 16'h0100, 1, 16'h2000);
  endtask

  // R7: oldest leaves first.
  task automatic t_evict();
    put(16'h0110, 16'h2400, 1);
    look("R7", 16'h0100, 0, 16'h0);
    look("R7", 16'h0104, 1, 16'h2100);
    look("R7", 16'h0110, 1, 16'h2400);
    put(16'h0114, 16'h2500, 1);
    look("R7", 16'h0104, 0, 16'h0);
    look("R7", 16'h0108, 1, 16'h2200);
    look("R7", 16'h0114, 1, 16'h2500);
  endtask

  // R8: rewrite in place, no extra slot used.
  task automatic t_in_place();
    apply_reset();
    put(16'h0100, 16'h2000, 1);
    put(16'h0104, 16'h2100, 1);
    put(16'h0108, 16'h2200, 1);
    put(16'h0104, 16'h5555, 1);
    look("R8", 16'h0104, 1, 16'h5555);
    put(16'h010C, 16'h2300, 1);
    look("R8", 16'h0100, 1, 16'h2000);
    look("R8", 16'h010C, 1, 16'h2300);
    put(16'h0110, 16'h2400, 1);
    look("R8", 16'h0100, 0, 16'h0);
    look("R8", 16'h0104, 1, 16'h5555);
  endtask

  // R3: redirect plus one wraps at 16 bits.
  task automatic t_wrap();
    apply_reset();
    put(16'h0300, 16'hFFFF, 1);
    look("R3", 16'h0300, 1, 16'hFFFF);
  endtask

  // R9: lookup and write in one cycle.
  task automatic t_same_cycle();
    apply_reset();
    @(negedge clk);
    upd_valid = 1; upd_taken = 1; upd_pc = 16'h0400; upd_target = 16'h1234;
    lk_valid = 1; lk_pc = 16'h0400;
    #1 cmp("R9", 16'h0400, 0, 16'h0);
    @(posedge clk);
    #1 upd_valid = 0; upd_taken = 0; lk_valid = 0;
    look("R9", 16'h0400, 1, 16'h1234);
    put(16'h0404, 16'h1300, 1);
    put(16'h0408, 16'h1400, 1);
    put(16'h040C, 16'h1500, 1);
    @(negedge clk);
    upd_valid = 1; upd_taken = 1; upd_pc = 16'h0410; upd_target = 16'h1600;
    lk_valid = 1; lk_pc = 16'h0400;
    #1 cmp("R9", 16'h0400, 1, 16'h1234);
    @(posedge clk);
    #1 upd_valid = 0; upd_taken = 0; lk_valid = 0;
    look("R9", 16'h0400, 0, 16'h0);
    look("R9", 16'h0410, 1, 16'h1600);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_idle();
    t_not_taken();
    t_evict();
    t_in_place();
    t_wrap();
    t_same_cycle();
    if (!done) begin
      done = 1;
      summary();
    end
  end

endmodule